// File: doc/BRIEF.md
# Channel Length Timer with Trigger Corrections

This block keeps the duration timer of a sound channel. Software loads a 6-bit length value, and the counter starts at 64 minus that value. While enabled, each length strobe from the frame sequencer takes one step off the counter. When the counter reaches zero, the channel's active flag drops. A control byte carries two bits: a trigger bit (bit 7) that restarts the channel, and an enable bit (bit 6) that lets the strobes count down.

The frame sequencer has phases that clock length and phases that do not. If a control write arrives in a phase that does not clock length (the extra-clock flag is high), two corrections apply. Turning the enable on from off costs one extra step. A trigger that leaves the counter at its full value of 64 starts it at 63 instead. The DAC-enable input decides whether a trigger can make the channel active. A power-off input clears all of the state.

Top module: `length_timer`

## Requirements
- R1: After reset the active flag is 0, the enable is 0, the counter is 0, and the control read-back is 0xBF.
- R2: A length-load write takes bits 5..0 of its data and sets the counter to 64 minus that value.
- R3: With the enable set and the counter nonzero, a length strobe decrements the counter by one. The decrement that reaches zero clears the active flag on the next cycle.
- R4: With the enable clear, a length strobe leaves the counter and the active flag unchanged.
- R5: The control read-back is 0xBF OR (enable << 6). All bits other than bit 6 read 1.
- R6: A control write with the extra-clock flag set decrements the counter once when all of these hold: the enable was 0, bit 6 sets it to 1, and the counter is nonzero. If this reaches zero, the channel goes inactive. There is no decrement when the enable was already 1 or when the flag is clear.
- R7: A control write with bit 7 set is a trigger. It sets the active flag only when the DAC input is high, and it reloads a zero counter to 64.
- R8: A trigger with the extra-clock flag set and the new enable set, which leaves the counter at 64, sets it to 63.
- R9: Within one control write, the extra decrement of R6 is applied before the trigger of R7 and R8.
- R10: A low DAC input forces the active flag to 0 on the next cycle, whatever else happens in that cycle.
- R11: The power-off input clears the counter, the enable and the active flag on the next cycle. It takes priority over every other input.
- R12: When events coincide in one cycle, they apply in this order: the length strobe, then the length-load write, then the control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_off_i | input | 1 | Clears counter, enable and active flag |
| len_wr_i | input | 1 | Length-load write strobe |
| len_data_i | input | 8 | Length-load data, bits 5..0 used |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_data_i | input | 8 | Control data: bit 7 trigger, bit 6 enable |
| len_tick_i | input | 1 | Length strobe from the frame sequencer |
| extra_phase_i | input | 1 | High during the sequencer phase that does not clock length |
| dac_on_i | input | 1 | DAC enabled |
| active_o | output | 1 | Channel active flag |
| ctl_rd_o | output | 8 | Control read-back value |

## Verification
The counter is not visible at the ports, so every check on its value is made by counting strobes until the active flag drops. The hardest case is a single extra-phase write that both turns the enable on and triggers, with the counter at 1. The decrement first drives it to zero and deactivates the channel. The trigger then reloads it to 64, trims it to 63 and reactivates it. The stimulus reaches this state by loading 63 and triggering with the enable off. It then issues that write and counts 63 strobes to expiry. Coinciding strobes, loads and writes are driven in single cycles to pin down the ordering.

// File: rtl/lt_pkg.sv
package lt_pkg;
    parameter int unsigned LOAD_W   = 6;
    parameter int unsigned BYTE_W   = 8;
    parameter int unsigned TRIG_POS = 7;
    parameter int unsigned EN_POS   = 6;
    parameter logic [BYTE_W-1:0] RD_FILL = 8'hBF;

    localparam int unsigned CNT_W = LOAD_W + 1;
    localparam int unsigned FULL  = 1 << LOAD_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en;
        logic             act;
    } lt_state_t;
endpackage

// File: rtl/lt_step.sv
module lt_step
    import lt_pkg::*;
(
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             go_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_zero_o
);
    logic nonzero;

    always_comb begin
        nonzero    = (cnt_i != '0);
        cnt_o      = cnt_i;
        hit_zero_o = 1'b0;
        if (go_i && nonzero) begin
            cnt_o      = cnt_i - CNT_W'(1);
            hit_zero_o = (cnt_i == CNT_W'(1));
        end
    end
endmodule

// File: rtl/lt_readback.sv
module lt_readback
    import lt_pkg::*;
(
    input  logic              en_i,
    output logic [BYTE_W-1:0] rd_o
);
    always_comb begin
        rd_o         = RD_FILL;
        rd_o[EN_POS] = en_i;
    end
endmodule

// File: rtl/length_timer.sv
module length_timer
    import lt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_off_i,
    input  logic              len_wr_i,
    input  logic [BYTE_W-1:0] len_data_i,
    input  logic              ctl_wr_i,
    input  logic [BYTE_W-1:0] ctl_data_i,
    input  logic              len_tick_i,
    input  logic              extra_phase_i,
    input  logic              dac_on_i,
    output logic              active_o,
    output logic [BYTE_W-1:0] ctl_rd_o
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FULL);

    lt_state_t st_d, st_q;

    logic             trig_req, en_req, extra_go;
    logic [CNT_W-1:0] cnt_after_tick, cnt_after_load, cnt_after_extra;
    logic             zero_tick, zero_extra;

    assign trig_req = ctl_wr_i && ctl_data_i[TRIG_POS];
    assign en_req   = ctl_data_i[EN_POS];
    assign extra_go = ctl_wr_i && extra_phase_i && !st_q.en && en_req;

    // stage 1: frame-sequencer strobe
    lt_step u_tick_step (
        .cnt_i      (st_q.cnt),
        .go_i       (len_tick_i && st_q.en),
        .cnt_o      (cnt_after_tick),
        .hit_zero_o (zero_tick)
    );

    // stage 2: length-load write
    always_comb begin
        cnt_after_load = cnt_after_tick;
        if (len_wr_i)
            cnt_after_load = CNT_FULL - {1'b0, len_data_i[LOAD_W-1:0]};
    end

    // stage 3: extra decrement on enable turn-on
    lt_step u_extra_step (
        .cnt_i      (cnt_after_load),
        .go_i       (extra_go),
        .cnt_o      (cnt_after_extra),
        .hit_zero_o (zero_extra)
    );

    // stage 4: trigger, DAC gating, power-off
    always_comb begin
        st_d     = st_q;
        st_d.act = st_q.act && !zero_tick && !zero_extra;
        st_d.cnt = cnt_after_extra;
        if (ctl_wr_i)
            st_d.en = en_req;
        if (trig_req) begin
            if (dac_on_i)
                st_d.act = 1'b1;
            if (st_d.cnt == '0)
                st_d.cnt = CNT_FULL;
            if (extra_phase_i && en_req && st_d.cnt == CNT_FULL)
                st_d.cnt = CNT_FULL - CNT_W'(1);
        end
        if (!dac_on_i)
            st_d.act = 1'b0;
        if (pwr_off_i)
            st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    lt_readback u_readback (
        .en_i (st_q.en),
        .rd_o (ctl_rd_o)
    );

    assign active_o = st_q.act;

    // R7
    act_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.act) |-> $past(ctl_wr_i && ctl_data_i[TRIG_POS] && dac_on_i && !pwr_off_i));

    // R10
    dac_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_on_i |=> !active_o);

    // R11
    pwr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off_i |=> (!active_o && st_q.cnt == '0 && !ctl_rd_o[EN_POS]));

    // R5
    rd_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && !pwr_off_i) |=> (ctl_rd_o[EN_POS] == $past(ctl_data_i[EN_POS])));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && !len_wr_i && !ctl_wr_i && !pwr_off_i) |=> $stable(st_q.cnt));

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_FULL);
endmodule

// File: tb/test_length_timer.sv
module test_length_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_off_i = 1'b0;
    logic       len_wr_i = 1'b0;
    logic [7:0] len_data_i = 8'h00;
    logic       ctl_wr_i = 1'b0;
    logic [7:0] ctl_data_i = 8'h00;
    logic       len_tick_i = 1'b0;
    logic       extra_phase_i = 1'b0;
    logic       dac_on_i = 1'b0;
    logic       active_o;
    logic [7:0] ctl_rd_o;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    int m_cnt = 0;
    int m_en = 0;
    int m_act = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    length_timer i_length_timer (
        .clk(clk), .rst_n(rst_n), .pwr_off_i(pwr_off_i),
        .len_wr_i(len_wr_i), .len_data_i(len_data_i),
        .ctl_wr_i(ctl_wr_i), .ctl_data_i(ctl_data_i),
        .len_tick_i(len_tick_i), .extra_phase_i(extra_phase_i),
        .dac_on_i(dac_on_i), .active_o(active_o), .ctl_rd_o(ctl_rd_o)
    );

    // Behavioural reference, applied in the order the requirements give (R12)
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_en = 0; m_act = 0;
        end else if (pwr_off_i) begin
            m_cnt = 0; m_en = 0; m_act = 0;
        end else begin
            if (len_tick_i && m_en == 1 && m_cnt > 0) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) m_act = 0;
            end
            if (len_wr_i) m_cnt = 64 - int'(len_data_i % 64);
            if (ctl_wr_i) begin
                if (extra_phase_i && m_en == 0 && ctl_data_i[6] && m_cnt > 0) begin
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) m_act = 0;
                end
                m_en = ctl_data_i[6] ? 1 : 0;
                if (ctl_data_i[7]) begin
                    if (dac_on_i) m_act = 1;
                    if (m_cnt == 0) m_cnt = 64;
                    if (extra_phase_i && m_en == 1 && m_cnt == 64) m_cnt = 63;
                end
            end
            if (!dac_on_i) m_act = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (active_o !== (m_act == 1) || ctl_rd_o !== (8'hBF | 8'(m_en << 6))) begin
                failures++;
                $display("FAIL %s model compare: actual act=%0d rd=%02h expected act=%0d rd=%02h",
                         cur_req, active_o, ctl_rd_o, m_act, 8'hBF | 8'(m_en << 6));
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input bit tk, input bit lw, input int lv,
                         input bit cw, input int cv, input bit ex, input bit po);
        len_tick_i = tk; len_wr_i = lw; len_data_i = 8'(lv);
        ctl_wr_i = cw; ctl_data_i = 8'(cv); extra_phase_i = ex; pwr_off_i = po;
        @(negedge clk);
        len_tick_i = 0; len_wr_i = 0; ctl_wr_i = 0; extra_phase_i = 0; pwr_off_i = 0;
    endtask

    task automatic wr_len(input int v);
        drive(0, 1, v, 0, 0, 0, 0);
    endtask

    task automatic wr_ctl(input int v, input bit ex);
        drive(0, 0, 0, 1, v, ex, 0);
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) drive(1, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic expire_after(input string req, input int n);
        strobes(n - 1);
        check(req, active_o, 1);
        strobes(1);
        check(req, active_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        check("R1", active_o, 0);
        check("R1", ctl_rd_o, 8'hBF);
        dac_on_i = 1;
        @(negedge clk);

        cur_req = "R3";
        wr_len(60);
        wr_ctl(8'hC0, 0);
        check("R7", active_o, 1);
        check("R5", ctl_rd_o, 8'hFF);
        expire_after("R3", 4);
        cur_req = "R2";
        wr_len(8'hC2); // upper bits ignored: 64-2
        wr_ctl(8'hC0, 0);
        expire_after("R2", 62);

        cur_req = "R4";
        wr_len(63);
        wr_ctl(8'h80, 0);
        check("R5", ctl_rd_o, 8'hBF);
        strobes(5);
        check("R4", active_o, 1);
        cur_req = "R6";
        wr_ctl(8'h40, 1);
        check("R6", active_o, 0);

        wr_len(62);
        wr_ctl(8'hC0, 0);
        wr_ctl(8'h40, 1);
        expire_after("R6", 2);
        wr_ctl(8'h00, 0);
        wr_len(62);
        wr_ctl(8'h80, 0);
        wr_ctl(8'h40, 0);
        expire_after("R6", 2);
        wr_ctl(8'h00, 0);
        wr_len(61);
        wr_ctl(8'h80, 0);
        wr_ctl(8'h40, 1);
        expire_after("R6", 2);

        cur_req = "R8";
        wr_ctl(8'hC0, 1);
        check("R8", active_o, 1);
        expire_after("R8", 63);
        cur_req = "R7";
        wr_ctl(8'hC0, 0);
        expire_after("R7", 64);

        cur_req = "R9";
        wr_ctl(8'h00, 0);
        wr_len(63);
        wr_ctl(8'h80, 0);
        wr_ctl(8'hC0, 1);
        check("R9", active_o, 1);
        expire_after("R9", 63);
        wr_ctl(8'h00, 0);
        wr_len(10);
        wr_ctl(8'hC0, 1);
        expire_after("R9", 53);

        cur_req = "R7";
        dac_on_i = 0;
        wr_len(0);
        wr_ctl(8'h80, 0);
        check("R7", active_o, 0);
        dac_on_i = 1;
        wr_ctl(8'h80, 0);
        check("R7", active_o, 1);
        cur_req = "R10";
        dac_on_i = 0;
        @(negedge clk);
        check("R10", active_o, 0);
        dac_on_i = 1;
        drive(0, 0, 0, 1, 8'h80, 0, 0);
        check("R10", active_o, 1);

        cur_req = "R11";
        wr_len(60);
        wr_ctl(8'hC0, 0);
        check("R11", ctl_rd_o, 8'hFF);
        drive(0, 0, 0, 0, 0, 0, 1);
        check("R11", active_o, 0);
        check("R11", ctl_rd_o, 8'hBF);
        wr_ctl(8'hC0, 0);
        expire_after("R11", 64);
        drive(0, 1, 5, 1, 8'hC0, 0, 1);
        check("R11", active_o, 0);

        cur_req = "R12";
        wr_len(50);
        wr_ctl(8'hC0, 0);
        drive(1, 1, 62, 0, 0, 0, 0);
        expire_after("R12", 2);
        drive(0, 1, 63, 1, 8'hC0, 0, 0);
        expire_after("R12", 1);
        drive(1, 1, 0, 1, 8'hC0, 1, 0);
        expire_after("R12", 63);

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule